// File: doc/BRIEF.md
# Tag-Capturing Reservation Station Array

This block is a small pool of waiting slots that sits in front of one execution unit in an out-of-order core. Each slot holds one operation, and the slot's own number (plus one) is the rename tag for that operation's result. When an operation is issued, each of its two sources comes either as a finished value or as the tag of the slot that will produce it. Slots that are still waiting watch a single result broadcast bus. When a broadcast tag matches one of their pending sources, they take the value from the bus.

A slot whose two sources both hold values asks to be dispatched. Each cycle at most one such slot is offered to the execution unit, and the oldest waiting slot goes first. A slot is released when the unit accepts its operation. The block raises a full flag so that the issue logic can stall, and it reports which tag the next issued operation will receive.

Top module: `rs_station`

## Requirements
- R1: While `rst_n` is low, every slot is empty. `fu_valid` reads 0, `iss_full` reads 0 and `iss_tag` reads 1.
- R2: An issued source whose tag is 0 is stored as a value and counts as ready. An operation whose sources are both ready appears on the execution port in the cycle after the issue edge, with its own op code and values. Its `fu_tag` equals the `iss_tag` shown when it was issued, and `iss_tag` is one plus the lowest-numbered empty slot.
- R3: A slot that still has a source with a nonzero (pending) tag is never offered; `fu_valid` stays 0 while no slot has both sources ready.
- R4: When `res_valid` is high and `res_tag` equals a pending source tag, that source takes `res_data` at the edge and becomes ready. If the slot's other source is already ready, the slot is offered in the next cycle.
- R5: If an issued source tag equals `res_tag` while `res_valid` is high in the same cycle, the slot stores `res_data` for that source and the source is ready at once.
- R6: `iss_full` is 1 exactly when every slot is occupied. An issue request made while `iss_full` is 1 is dropped and changes nothing, and the flag stays set until a dispatch is accepted.
- R7: Among ready slots, the one issued earliest is offered. When a slot is reused, it counts as younger than every slot still held.
- R8: A slot is released at the edge where `fu_valid` and `fu_ready` are both high. That slot is not offered again in the next cycle, a full array shows `iss_full` = 0 in the next cycle, and the slot can be issued into again from that cycle on.
- R9: Tag 0 means "no producer". Every tag the block hands out or offers lies in 1..NUM_ENT.
- R10: A broadcast whose tag matches no pending source, or a bus carrying a matching tag while `res_valid` is low, changes no slot.
- R11: Once `fu_valid` is high, it stays high until an offer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued operation |
| iss_src_a_tag | input | TAG_W | Producer tag of source A, 0 when the value is given |
| iss_src_a_val | input | DATA_W | Value of source A |
| iss_src_b_tag | input | TAG_W | Producer tag of source B, 0 when the value is given |
| iss_src_b_val | input | DATA_W | Value of source B |
| iss_full | output | 1 | No empty slot; issue must stall |
| iss_tag | output | TAG_W | Tag the next accepted issue will receive |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_data | input | DATA_W | Broadcast result value |
| fu_valid | output | 1 | A ready operation is offered |
| fu_ready | input | 1 | Execution unit accepts the offer |
| fu_op | output | OP_W | Offered operation code |
| fu_tag | output | TAG_W | Destination tag of the offered operation |
| fu_src_a | output | DATA_W | Offered source A value |
| fu_src_b | output | DATA_W | Offered source B value |

## Verification
The directed patterns cover several distinct cases. Issuing with both sources ready shows the plain value path. A source that waits on a tag, followed by a broadcast that does not match it and then one that does, separates a correct tag compare from a bus that wakes everything. An issue whose pending tag is broadcast in the same cycle shows whether the snoop at issue works. After the array is filled, slots are released in an order that makes the youngest slot the lowest-numbered one, which separates oldest-first selection from a plain lowest-index pick. Random traffic with mixed ready and pending sources, random broadcasts and a random accept signal is then compared cycle by cycle against a reference model that orders slots by issue sequence numbers.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;

  // Tag value meaning "operand already present, no producer pending".
  localparam int unsigned TAG_NONE = 0;

  typedef int unsigned tag_num_t;

  // True when a live broadcast carries the tag a source is waiting for.
  function automatic logic bus_hits(input logic bus_valid,
                                    input tag_num_t bus_tag,
                                    input tag_num_t src_tag);
    return bus_valid && (src_tag != TAG_NONE) && (bus_tag == src_tag);
  endfunction

endpackage

// File: rtl/rs_alloc.sv
`timescale 1ns/1ps
module rs_alloc #(
  parameter  int NUM_ENT = 4,
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0] valid_vec,
  output logic [IDX_W-1:0]   free_idx,
  output logic               any_free
);

  // Lowest-numbered empty slot wins.
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = i[IDX_W-1:0];
        any_free = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              release_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_ta_i,
  input  logic [DATA_W-1:0] iss_da_i,
  input  logic [TAG_W-1:0]  iss_tb_i,
  input  logic [DATA_W-1:0] iss_db_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              valid_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);

  logic              valid_q, valid_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [TAG_W-1:0]  ta_q, ta_d, tb_q, tb_d;
  logic [DATA_W-1:0] da_q, da_d, db_q, db_d;
  logic              wake_a, wake_b, snap_a, snap_b, body_en;

  always_comb begin
    wake_a  = valid_q && bus_hits(bus_valid_i, tag_num_t'(bus_tag_i), tag_num_t'(ta_q));
    wake_b  = valid_q && bus_hits(bus_valid_i, tag_num_t'(bus_tag_i), tag_num_t'(tb_q));
    snap_a  = bus_hits(bus_valid_i, tag_num_t'(bus_tag_i), tag_num_t'(iss_ta_i));
    snap_b  = bus_hits(bus_valid_i, tag_num_t'(bus_tag_i), tag_num_t'(iss_tb_i));
    body_en = alloc_i || wake_a || wake_b;

    valid_d = valid_q;
    if (release_i) valid_d = 1'b0;
    if (alloc_i)   valid_d = 1'b1;

    op_d = op_q;
    ta_d = ta_q;
    da_d = da_q;
    tb_d = tb_q;
    db_d = db_q;
    if (alloc_i) begin
      op_d = iss_op_i;
      ta_d = snap_a ? '0 : iss_ta_i;
      da_d = snap_a ? bus_data_i : iss_da_i;
      tb_d = snap_b ? '0 : iss_tb_i;
      db_d = snap_b ? bus_data_i : iss_db_i;
    end else begin
      if (wake_a) begin
        ta_d = '0;
        da_d = bus_data_i;
      end
      if (wake_b) begin
        tb_d = '0;
        db_d = bus_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (body_en) begin
      op_q <= op_d;
      ta_q <= ta_d;
      da_q <= da_d;
      tb_q <= tb_d;
      db_q <= db_d;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (ta_q == '0) && (tb_q == '0);
  assign op_o    = op_q;
  assign a_o     = da_q;
  assign b_o     = db_q;

endmodule

// File: rtl/rs_age_select.sv
`timescale 1ns/1ps
module rs_age_select #(
  parameter  int NUM_ENT = 4,
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] alloc_vec,
  input  logic [NUM_ENT-1:0] valid_vec,
  input  logic [NUM_ENT-1:0] ready_vec,
  output logic [NUM_ENT-1:0] grant_vec,
  output logic [IDX_W-1:0]   grant_idx,
  output logic               any_ready
);

  // Bit i*NUM_ENT+j set: slot i was issued before slot j.
  logic [NUM_ENT*NUM_ENT-1:0] older_q, older_d;
  logic [NUM_ENT-1:0]         blocked, elig;
  logic                       age_en, found;

  always_comb begin
    age_en  = |alloc_vec;
    older_d = older_q;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = 0; j < NUM_ENT; j++) begin
        if (alloc_vec[j]) older_d[i*NUM_ENT+j] = valid_vec[i] && (i != j);
        if (alloc_vec[i]) older_d[i*NUM_ENT+j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      older_q <= '0;
    else if (age_en) older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NUM_ENT; j++) begin
        blocked[i] = blocked[i] | (ready_vec[j] & older_q[j*NUM_ENT+i]);
      end
      elig[i] = ready_vec[i] & ~blocked[i];
    end
    grant_vec = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (elig[i] && !found) begin
        grant_vec[i] = 1'b1;
        grant_idx    = i[IDX_W-1:0];
        found        = 1'b1;
      end
    end
    any_ready = |ready_vec;
  end

endmodule

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station #(
  parameter  int NUM_ENT = 4,
  parameter  int DATA_W  = 16,
  parameter  int OP_W    = 4,
  localparam int TAG_W   = $clog2(NUM_ENT + 1),
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_src_a_tag,
  input  logic [DATA_W-1:0] iss_src_a_val,
  input  logic [TAG_W-1:0]  iss_src_b_tag,
  input  logic [DATA_W-1:0] iss_src_b_val,
  output logic              iss_full,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              fu_valid,
  input  logic              fu_ready,
  output logic [OP_W-1:0]   fu_op,
  output logic [TAG_W-1:0]  fu_tag,
  output logic [DATA_W-1:0] fu_src_a,
  output logic [DATA_W-1:0] fu_src_b
);

  logic [NUM_ENT-1:0] valid_vec, ready_vec, alloc_vec, release_vec, grant_vec;
  logic [IDX_W-1:0]   free_idx, grant_idx;
  logic               any_free, any_ready, iss_fire, fu_fire;
  logic [OP_W-1:0]    ent_op [NUM_ENT];
  logic [DATA_W-1:0]  ent_a  [NUM_ENT];
  logic [DATA_W-1:0]  ent_b  [NUM_ENT];

  rs_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
    .valid_vec (valid_vec),
    .free_idx  (free_idx),
    .any_free  (any_free)
  );

  assign iss_fire = iss_valid && any_free;
  assign fu_fire  = fu_valid && fu_ready;

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
      assign alloc_vec[g]   = iss_fire && (free_idx == IDX_W'(g));
      assign release_vec[g] = fu_fire && grant_vec[g];

      rs_entry #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W)) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc_vec[g]),
        .release_i   (release_vec[g]),
        .iss_op_i    (iss_op),
        .iss_ta_i    (iss_src_a_tag),
        .iss_da_i    (iss_src_a_val),
        .iss_tb_i    (iss_src_b_tag),
        .iss_db_i    (iss_src_b_val),
        .bus_valid_i (res_valid),
        .bus_tag_i   (res_tag),
        .bus_data_i  (res_data),
        .valid_o     (valid_vec[g]),
        .ready_o     (ready_vec[g]),
        .op_o        (ent_op[g]),
        .a_o         (ent_a[g]),
        .b_o         (ent_b[g])
      );
    end
  endgenerate

  rs_age_select #(.NUM_ENT(NUM_ENT)) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vec (alloc_vec),
    .valid_vec (valid_vec),
    .ready_vec (ready_vec),
    .grant_vec (grant_vec),
    .grant_idx (grant_idx),
    .any_ready (any_ready)
  );

  assign iss_full = !any_free;
  assign iss_tag  = TAG_W'(free_idx) + TAG_W'(1);
  assign fu_valid = any_ready;
  assign fu_tag   = TAG_W'(grant_idx) + TAG_W'(1);
  assign fu_op    = ent_op[grant_idx];
  assign fu_src_a = ent_a[grant_idx];
  assign fu_src_b = ent_b[grant_idx];

endmodule

// File: rtl/rs_station_checker.sv
`timescale 1ns/1ps
module rs_station_checker #(
  parameter int NUM_ENT = 4,
  parameter int TAG_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_full,
  input logic               fu_valid,
  input logic               fu_ready,
  input logic [TAG_W-1:0]   fu_tag,
  input logic [NUM_ENT-1:0] grant_vec
);

  assert_tag_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid |-> (fu_tag != '0) && (fu_tag <= TAG_W'(NUM_ENT)));

  assert_offer_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_valid && !fu_ready) |=> fu_valid);

  assert_stall_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_full && !(fu_valid && fu_ready)) |=> iss_full);

  assert_full_reopens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_full && fu_valid && fu_ready) |=> !iss_full);

  assert_freed_not_reoffered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_valid && fu_ready) |=> !(fu_valid && (fu_tag == $past(fu_tag))));

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

endmodule

bind rs_station rs_station_checker #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_full  (iss_full),
  .fu_valid  (fu_valid),
  .fu_ready  (fu_ready),
  .fu_tag    (fu_tag),
  .grant_vec (grant_vec)
);

// File: tb/rs_station_bench.sv
`timescale 1ns/1ps
module rs_station_bench;

  localparam int N  = 4;
  localparam int DW = 16;
  localparam int OW = 4;
  localparam int TW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          b_iv, b_bv, b_fr;
  logic [OW-1:0] b_op;
  logic [TW-1:0] b_ta, b_tb, b_bt;
  logic [DW-1:0] b_da, b_db, b_bd;
  logic          iss_full, fu_valid;
  logic [TW-1:0] iss_tag, fu_tag;
  logic [OW-1:0] fu_op;
  logic [DW-1:0] fu_a, fu_b;

  rs_station u_rs_station (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(b_iv), .iss_op(b_op),
    .iss_src_a_tag(b_ta), .iss_src_a_val(b_da),
    .iss_src_b_tag(b_tb), .iss_src_b_val(b_db),
    .iss_full(iss_full), .iss_tag(iss_tag),
    .res_valid(b_bv), .res_tag(b_bt), .res_data(b_bd),
    .fu_valid(fu_valid), .fu_ready(b_fr), .fu_op(fu_op),
    .fu_tag(fu_tag), .fu_src_a(fu_a), .fu_src_b(fu_b)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model: slots ordered by issue sequence number.
  bit            m_v  [N];
  logic [OW-1:0] m_op [N];
  logic [TW-1:0] m_ta [N], m_tb [N];
  logic [DW-1:0] m_da [N], m_db [N];
  int            m_seq[N];
  int            seq_ctr = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_sel();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_ta[i] == 0 && m_tb[i] == 0 && (best < 0 || m_seq[i] < m_seq[best]))
        best = i;
    return best;
  endfunction

  function automatic int exp_free();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic compare_all();
    int s = exp_sel();
    int f = exp_free();
    chk("R6 full flag", iss_full, (f < 0));
    if (f >= 0) chk("R2 next tag", iss_tag, f + 1);
    chk("R3 offer valid", fu_valid, (s >= 0));
    if (s >= 0) begin
      chk("R7 selected tag", fu_tag, s + 1);
      chk("R2 op", fu_op, m_op[s]);
      chk("R4 src a", fu_a, m_da[s]);
      chk("R4 src b", fu_b, m_db[s]);
    end
  endtask

  task automatic model_update();
    int s = exp_sel();
    int f = exp_free();
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && b_bv && m_ta[i] != 0 && m_ta[i] == b_bt) begin m_ta[i] = 0; m_da[i] = b_bd; end
      if (m_v[i] && b_bv && m_tb[i] != 0 && m_tb[i] == b_bt) begin m_tb[i] = 0; m_db[i] = b_bd; end
    end
    if (s >= 0 && b_fr) m_v[s] = 1'b0;
    if (b_iv && f >= 0) begin
      m_v[f]  = 1'b1;
      m_op[f] = b_op;
      if (b_ta != 0 && b_bv && b_bt == b_ta) begin m_ta[f] = 0; m_da[f] = b_bd; end
      else begin m_ta[f] = b_ta; m_da[f] = b_da; end
      if (b_tb != 0 && b_bv && b_bt == b_tb) begin m_tb[f] = 0; m_db[f] = b_bd; end
      else begin m_tb[f] = b_tb; m_db[f] = b_db; end
      m_seq[f] = seq_ctr;
      seq_ctr++;
    end
  endtask

  // Apply one cycle of stimulus; returns one time unit after the edge.
  task automatic drive(input bit iv, input logic [OW-1:0] op,
                       input logic [TW-1:0] ta, input logic [DW-1:0] da,
                       input logic [TW-1:0] tb, input logic [DW-1:0] db,
                       input bit bv, input logic [TW-1:0] bt, input logic [DW-1:0] bd,
                       input bit fr);
    @(negedge clk);
    b_iv = iv; b_op = op; b_ta = ta; b_da = da; b_tb = tb; b_db = db;
    b_bv = bv; b_bt = bt; b_bd = bd; b_fr = fr;
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic idle(input bit fr);
    drive(1'b0, '0, '0, '0, '0, '0, 1'b0, '0, '0, fr);
  endtask

  initial begin
    rst_n = 1'b0;
    b_iv = 0; b_op = '0; b_ta = '0; b_da = '0; b_tb = '0; b_db = '0;
    b_bv = 0; b_bt = '0; b_bd = '0; b_fr = 0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 fu_valid in reset", fu_valid, 0);
    chk("R1 iss_full in reset", iss_full, 0);
    chk("R1 iss_tag in reset", iss_tag, 1);
    rst_n = 1'b1;

    // R2: both sources given as values
    drive(1, 4'h3, 0, 16'h0011, 0, 16'h0022, 0, 0, 0, 0);
    chk("R2 offered", fu_valid, 1);
    chk("R2 tag", fu_tag, 1);
    chk("R2 value a", fu_a, 16'h0011);
    chk("R2 value b", fu_b, 16'h0022);
    idle(0); idle(0);
    chk("R11 offer held", fu_valid, 1);
    // R3: source waiting on tag 1; older slot stays selected
    drive(1, 4'h5, 1, 16'h0000, 0, 16'h0033, 0, 0, 0, 0);
    chk("R7 older kept", fu_tag, 1);
    // R10: unrelated tag broadcast while slot 1 is accepted
    drive(0, 0, 0, 0, 0, 0, 1, 3, 16'h0099, 1);
    chk("R10 unmatched tag", fu_valid, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 16'h0044, 0);
    chk("R10 bus not valid", fu_valid, 0);
    // R4: matching broadcast wakes the slot
    drive(0, 0, 0, 0, 0, 0, 1, 1, 16'h0044, 0);
    chk("R4 woken", fu_valid, 1);
    chk("R4 tag", fu_tag, 2);
    chk("R4 captured", fu_a, 16'h0044);
    chk("R4 kept b", fu_b, 16'h0033);
    idle(1);
    chk("R8 drained", fu_valid, 0);
    // R5: broadcast in the same cycle as issue
    drive(1, 4'h6, 4, 16'hdead, 0, 16'h0055, 1, 4, 16'h0066, 0);
    chk("R5 ready at once", fu_valid, 1);
    chk("R5 captured", fu_a, 16'h0066);
    idle(1);
    // R6: fill the array with waiting slots
    for (int k = 0; k < N; k++) drive(1, OW'(k), 2, 0, 0, DW'(k), 0, 0, 0, 0);
    chk("R6 full", iss_full, 1);
    drive(1, 4'hf, 0, 16'h0001, 0, 16'h0001, 0, 0, 0, 0);
    chk("R6 still full", iss_full, 1);
    chk("R6 dropped issue", fu_valid, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 2, 16'h0077, 0);
    chk("R7 oldest first", fu_tag, 1);
    chk("R4 broadcast to all", fu_a, 16'h0077);
    idle(1);
    chk("R8 reopened", iss_full, 0);
    chk("R8 reuse tag", iss_tag, 1);
    drive(1, 4'h9, 0, 16'h0005, 0, 16'h0006, 0, 0, 0, 1);
    chk("R7 age order", fu_tag, 3);
    idle(1);
    chk("R7 older beats low index", fu_tag, 4);
    idle(1);
    chk("R7 youngest last", fu_tag, 1);
    chk("R8 reused slot value", fu_a, 16'h0005);
    idle(1);
    chk("R9 empty", fu_valid, 0);

    // Random traffic
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4000; c++) begin
      bit iv = ($urandom % 100) < 60;
      logic [TW-1:0] ta = (($urandom % 2) == 0) ? TW'(0) : TW'(1 + $urandom % N);
      logic [TW-1:0] tb = (($urandom % 3) == 0) ? TW'(1 + $urandom % N) : TW'(0);
      bit bv = ($urandom % 100) < 40;
      drive(iv, OW'($urandom), ta, DW'($urandom), tb, DW'($urandom),
            bv, TW'(1 + $urandom % N), DW'($urandom), ($urandom % 100) < 60);
      if (fu_valid) chk("R9 tag range", (fu_tag >= 1 && fu_tag <= N), 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule